// File: doc/BRIEF.md
# Address Translation Unit with Hardware Table Walk and Page-Fault Trap

This block turns the virtual address of every instruction fetch, load and store into a physical address before memory is touched. A small fully associative translation cache is searched first. On a hit, the physical frame number is joined to the untouched page-offset bits and returned. On a miss, the unit makes one read of the page table in memory, at the table base register plus the virtual page number. A valid entry is written into the translation cache, and the lookup is then repeated so that it hits.

An entry whose valid bit is clear causes a precise page fault. The unit saves the program counter it holds as the exception PC. It also records the faulting virtual address and a cause code that names the access kind, then moves the program counter to the handler address. A return-from-exception input copies the saved PC back, so the faulting instruction runs again from its start. If the table has been repaired in the meantime, the retried access walks, refills and completes.

The control is a five-state machine. IDLE accepts a request and moves to LOOK. LOOK either answers on a hit and returns to IDLE, or moves to WREQ on a miss. WREQ issues the table read and moves to WWAIT. WWAIT waits for the read data. A valid entry takes it back to LOOK, and an invalid entry takes it to FAULT. FAULT pulses the trap output for one cycle and returns to IDLE.

Top module: `xl_translate_unit`

## Requirements
- R1: After reset, pc equals RESET_PC, cause is 0, trap, resp_valid and ptw_req are low, req_ready is high and the translation cache holds no valid entry.
- R2: A request whose page is cached is accepted in one cycle and answered in the next cycle with resp_paddr = {PFN, vaddr[PAGE_W-1:0]}, with no table read.
- R3: A missed page produces exactly one ptw_req pulse with ptw_addr = table base + virtual page number (vaddr[VA_W-1:PAGE_W]). No second read is issued and resp_valid stays low until ptw_rvalid returns.
- R4: A table entry with bit PFN_W set is valid, and its bits PFN_W-1:0 are the frame. It is written into the cache and the access then completes with that frame. A later access to the same page hits.
- R5: A table entry with bit PFN_W clear raises a fault. epc takes the current pc and badva takes the request address. cause becomes 1 for a fetch (req_kind 0), 2 for a load (req_kind 1) and 3 for a store (req_kind 2 or 3). pc becomes HANDLER, trap is high for exactly one cycle, and no response is given.
- R6: rfe loads pc from epc and clears cause to 0, so the retried access walks the table again.
- R7: pc_set loads pc from pc_wdata when rfe is low and no fault is being taken.
- R8: flush invalidates every cache entry and returns the replacement pointer to entry 0.
- R9: ptbase_we loads the table base from ptbase_wdata and has the same invalidating effect as flush. Later walks use the new base.
- R10: Refills go to entries in round-robin order 0, 1, ..., ENTRIES-1, 0. The entry filled longest ago is the one overwritten.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request |
| req_kind | input | 2 | 0 fetch, 1 load, 2/3 store |
| req_vaddr | input | VA_W | Virtual address |
| req_ready | output | 1 | Unit idle, request taken |
| resp_valid | output | 1 | Translation done |
| resp_paddr | output | PFN_W+PAGE_W | Physical address |
| ptw_req | output | 1 | Page-table read pulse |
| ptw_addr | output | PT_AW | Page-table entry address |
| ptw_rvalid | input | 1 | Table read data valid |
| ptw_rdata | input | PFN_W+1 | Entry: valid bit on top, frame below |
| ptbase_we | input | 1 | Write table base |
| ptbase_wdata | input | PT_AW | New table base |
| flush | input | 1 | Invalidate all cached entries |
| pc_set | input | 1 | Load program counter |
| pc_wdata | input | VA_W | New program counter |
| rfe | input | 1 | Return from exception |
| pc | output | VA_W | Program counter |
| epc | output | VA_W | Saved exception PC |
| badva | output | VA_W | Faulting virtual address |
| cause | output | 2 | Fault cause code |
| trap | output | 1 | Fault taken pulse |

## Verification
The bench builds the unit with a 4-entry cache, 16-bit virtual addresses, 8-bit pages and 8-bit frames, with the handler at 0x8000. Four entries bring full wrap-around of the round-robin pointer within a handful of accesses, so the bench can see eviction of the oldest page. Eight-bit page numbers let the bench model the whole table as a small array. Every fault can then be repaired by setting one valid bit and retried.

// File: rtl/xl_pkg.sv
package xl_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOOK,
        ST_WREQ,
        ST_WWAIT,
        ST_FAULT
    } xl_state_e;

    localparam logic [1:0] CAUSE_NONE  = 2'd0;
    localparam logic [1:0] CAUSE_FETCH = 2'd1;
    localparam logic [1:0] CAUSE_LOAD  = 2'd2;
    localparam logic [1:0] CAUSE_STORE = 2'd3;

    function automatic logic [1:0] kind_to_cause(input logic [1:0] kind);
        unique case (kind)
            2'd0:    return CAUSE_FETCH;
            2'd1:    return CAUSE_LOAD;
            default: return CAUSE_STORE;
        endcase
    endfunction
endpackage

// File: rtl/xl_tlb.sv
module xl_tlb #(
    parameter int ENTRIES = 8,
    parameter int VPN_W   = 8,
    parameter int PFN_W   = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [VPN_W-1:0] lk_vpn,
    output logic             hit,
    output logic [PFN_W-1:0] hit_pfn,
    input  logic             fill_en,
    input  logic [VPN_W-1:0] fill_vpn,
    input  logic [PFN_W-1:0] fill_pfn,
    input  logic             clear
);
    localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
    localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

    logic [ENTRIES-1:0] vld;
    logic [VPN_W-1:0]   tag [ENTRIES];
    logic [PFN_W-1:0]   frm [ENTRIES];
    logic [IDX_W-1:0]   ptr;
    logic [ENTRIES-1:0] match;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign match[g] = vld[g] && (tag[g] == lk_vpn);
    end

    assign hit = |match;

    always_comb begin
        hit_pfn = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (match[i]) hit_pfn = hit_pfn | frm[i];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            vld <= '0;
            ptr <= '0;
            if (!rst_n) begin
                for (int i = 0; i < ENTRIES; i++) begin
                    tag[i] <= '0;
                    frm[i] <= '0;
                end
            end
        end else if (fill_en) begin
            for (int i = 0; i < ENTRIES; i++) begin
                if (ptr == IDX_W'(i)) begin
                    vld[i] <= 1'b1;
                    tag[i] <= fill_vpn;
                    frm[i] <= fill_pfn;
                end
            end
            ptr <= (ptr == LAST) ? '0 : ptr + 1'b1;
        end
    end
endmodule

// File: rtl/xl_trap_regs.sv
module xl_trap_regs #(
    parameter int              VA_W     = 16,
    parameter logic [VA_W-1:0] HANDLER  = '0,
    parameter logic [VA_W-1:0] RESET_PC = '0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            fault_en,
    input  logic [1:0]      fault_cause,
    input  logic [VA_W-1:0] fault_va,
    input  logic            rfe,
    input  logic            pc_set,
    input  logic [VA_W-1:0] pc_wdata,
    output logic [VA_W-1:0] pc,
    output logic [VA_W-1:0] epc,
    output logic [VA_W-1:0] badva,
    output logic [1:0]      cause
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc    <= RESET_PC;
            epc   <= '0;
            badva <= '0;
            cause <= xl_pkg::CAUSE_NONE;
        end else if (fault_en) begin
            epc   <= pc;
            badva <= fault_va;
            cause <= fault_cause;
            pc    <= HANDLER;
        end else if (rfe) begin
            pc    <= epc;
            cause <= xl_pkg::CAUSE_NONE;
        end else if (pc_set) begin
            pc    <= pc_wdata;
        end
    end
endmodule

// File: rtl/xl_translate_unit.sv
module xl_translate_unit #(
    parameter int                   VA_W       = 16,
    parameter int                   PAGE_W     = 8,
    parameter int                   PFN_W      = 8,
    parameter int                   ENTRIES    = 8,
    parameter int                   PT_AW      = 16,
    parameter logic [VA_W-1:0]      HANDLER    = 16'h8000,
    parameter logic [VA_W-1:0]      RESET_PC   = '0,
    parameter logic [PT_AW-1:0]     PTBASE_RST = '0
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    req_valid,
    input  logic [1:0]              req_kind,
    input  logic [VA_W-1:0]         req_vaddr,
    output logic                    req_ready,
    output logic                    resp_valid,
    output logic [PFN_W+PAGE_W-1:0] resp_paddr,
    output logic                    ptw_req,
    output logic [PT_AW-1:0]        ptw_addr,
    input  logic                    ptw_rvalid,
    input  logic [PFN_W:0]          ptw_rdata,
    input  logic                    ptbase_we,
    input  logic [PT_AW-1:0]        ptbase_wdata,
    input  logic                    flush,
    input  logic                    pc_set,
    input  logic [VA_W-1:0]         pc_wdata,
    input  logic                    rfe,
    output logic [VA_W-1:0]         pc,
    output logic [VA_W-1:0]         epc,
    output logic [VA_W-1:0]         badva,
    output logic [1:0]              cause,
    output logic                    trap
);
    import xl_pkg::*;

    localparam int VPN_W = VA_W - PAGE_W;

    xl_state_e          st, st_nxt;
    logic [VA_W-1:0]    q_va;
    logic [1:0]         q_kind;
    logic [PT_AW-1:0]   ptbase;
    logic               accept, fill_en, fault_en, tlb_hit;
    logic [PFN_W-1:0]   tlb_pfn;
    logic [VPN_W-1:0]   q_vpn;

    assign q_vpn = q_va[VA_W-1:PAGE_W];

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= st_nxt;
    end

    // Next state and outputs
    always_comb begin
        st_nxt     = st;
        accept     = 1'b0;
        resp_valid = 1'b0;
        ptw_req    = 1'b0;
        fill_en    = 1'b0;
        fault_en   = 1'b0;
        trap       = 1'b0;
        unique case (st)
            ST_IDLE: begin
                if (req_valid) begin
                    accept = 1'b1;
                    st_nxt = ST_LOOK;
                end
            end
            ST_LOOK: begin
                if (tlb_hit) begin
                    resp_valid = 1'b1;
                    st_nxt     = ST_IDLE;
                end else begin
                    st_nxt = ST_WREQ;
                end
            end
            ST_WREQ: begin
                ptw_req = 1'b1;
                st_nxt  = ST_WWAIT;
            end
            ST_WWAIT: begin
                if (ptw_rvalid) begin
                    if (ptw_rdata[PFN_W]) begin
                        fill_en = 1'b1;
                        st_nxt  = ST_LOOK;
                    end else begin
                        fault_en = 1'b1;
                        st_nxt   = ST_FAULT;
                    end
                end
            end
            ST_FAULT: begin
                trap   = 1'b1;
                st_nxt = ST_IDLE;
            end
            default: st_nxt = ST_IDLE;
        endcase
    end

    assign req_ready  = (st == ST_IDLE);
    assign resp_paddr = {tlb_pfn, q_va[PAGE_W-1:0]};
    assign ptw_addr   = ptbase + PT_AW'(q_vpn);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_va   <= '0;
            q_kind <= '0;
            ptbase <= PTBASE_RST;
        end else begin
            if (accept) begin
                q_va   <= req_vaddr;
                q_kind <= req_kind;
            end
            if (ptbase_we) ptbase <= ptbase_wdata;
        end
    end

    xl_tlb #(
        .ENTRIES (ENTRIES),
        .VPN_W   (VPN_W),
        .PFN_W   (PFN_W)
    ) u_tlb (
        .clk      (clk),
        .rst_n    (rst_n),
        .lk_vpn   (q_vpn),
        .hit      (tlb_hit),
        .hit_pfn  (tlb_pfn),
        .fill_en  (fill_en),
        .fill_vpn (q_vpn),
        .fill_pfn (ptw_rdata[PFN_W-1:0]),
        .clear    (flush || ptbase_we)
    );

    xl_trap_regs #(
        .VA_W     (VA_W),
        .HANDLER  (HANDLER),
        .RESET_PC (RESET_PC)
    ) u_trap (
        .clk         (clk),
        .rst_n       (rst_n),
        .fault_en    (fault_en),
        .fault_cause (kind_to_cause(q_kind)),
        .fault_va    (q_va),
        .rfe         (rfe),
        .pc_set      (pc_set),
        .pc_wdata    (pc_wdata),
        .pc          (pc),
        .epc         (epc),
        .badva       (badva),
        .cause       (cause)
    );
endmodule

// File: rtl/xl_translate_chk.sv
module xl_translate_chk #(
    parameter int               VA_W       = 16,
    parameter int               PAGE_W     = 8,
    parameter int               PFN_W      = 8,
    parameter int               PT_AW      = 16,
    parameter logic [VA_W-1:0]  HANDLER    = '0,
    parameter logic [PT_AW-1:0] PTBASE_RST = '0
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    req_valid,
    input logic [VA_W-1:0]         req_vaddr,
    input logic                    req_ready,
    input logic                    resp_valid,
    input logic [PFN_W+PAGE_W-1:0] resp_paddr,
    input logic                    ptw_req,
    input logic [PT_AW-1:0]        ptw_addr,
    input logic                    ptw_rvalid,
    input logic                    ptbase_we,
    input logic [PT_AW-1:0]        ptbase_wdata,
    input logic                    rfe,
    input logic [VA_W-1:0]         pc,
    input logic [VA_W-1:0]         epc,
    input logic [VA_W-1:0]         badva,
    input logic [1:0]              cause,
    input logic                    trap
);
    logic             outstanding;
    logic [VA_W-1:0]  cap_va;
    logic [PT_AW-1:0] base_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            outstanding <= 1'b0;
            cap_va      <= '0;
            base_q      <= PTBASE_RST;
        end else begin
            if (ptw_req)         outstanding <= 1'b1;
            else if (ptw_rvalid) outstanding <= 1'b0;
            if (req_valid && req_ready) cap_va <= req_vaddr;
            if (ptbase_we) base_q <= ptbase_wdata;
        end
    end

    assert_walk_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        outstanding |-> !resp_valid);
    assert_single_walk_R3: assert property (@(posedge clk) disable iff (!rst_n)
        outstanding |-> !ptw_req);
    assert_walk_addr_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ptw_req |-> ptw_addr == base_q + PT_AW'(cap_va[VA_W-1:PAGE_W]));
    assert_offset_kept_R2: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |-> resp_paddr[PAGE_W-1:0] == cap_va[PAGE_W-1:0]);
    assert_trap_state_R5: assert property (@(posedge clk) disable iff (!rst_n)
        trap |-> (pc == HANDLER && cause != 2'd0 && badva == cap_va && !resp_valid));
    assert_rfe_restore_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rfe && req_ready) |=> (pc == $past(epc) && cause == 2'd0));
endmodule

bind xl_translate_unit xl_translate_chk #(
    .VA_W       (VA_W),
    .PAGE_W     (PAGE_W),
    .PFN_W      (PFN_W),
    .PT_AW      (PT_AW),
    .HANDLER    (HANDLER),
    .PTBASE_RST (PTBASE_RST)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_vaddr    (req_vaddr),
    .req_ready    (req_ready),
    .resp_valid   (resp_valid),
    .resp_paddr   (resp_paddr),
    .ptw_req      (ptw_req),
    .ptw_addr     (ptw_addr),
    .ptw_rvalid   (ptw_rvalid),
    .ptbase_we    (ptbase_we),
    .ptbase_wdata (ptbase_wdata),
    .rfe          (rfe),
    .pc           (pc),
    .epc          (epc),
    .badva        (badva),
    .cause        (cause),
    .trap         (trap)
);

// File: tb/tb_xl_translate_unit.sv
`timescale 1ns/1ps
module tb_xl_translate_unit;
    localparam int VA_W = 16, PAGE_W = 8, PFN_W = 8, ENTRIES = 4, PT_AW = 16;
    localparam logic [15:0] HANDLER = 16'h8000;

    logic clk = 0, rst_n = 0;
    always #2.5 clk = ~clk;

    logic              req_valid = 0, ptw_rvalid = 0, ptbase_we = 0, flush = 0, pc_set = 0, rfe = 0;
    logic [1:0]        req_kind = 0;
    logic [15:0]       req_vaddr = 0, ptbase_wdata = 0, pc_wdata = 0;
    logic [PFN_W:0]    ptw_rdata = 0;
    logic              req_ready, resp_valid, ptw_req, trap;
    logic [15:0]       resp_paddr, ptw_addr, pc, epc, badva;
    logic [1:0]        cause;

    xl_translate_unit #(.VA_W(VA_W), .PAGE_W(PAGE_W), .PFN_W(PFN_W), .ENTRIES(ENTRIES),
                        .PT_AW(PT_AW), .HANDLER(HANDLER)) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
        .req_vaddr(req_vaddr), .req_ready(req_ready), .resp_valid(resp_valid),
        .resp_paddr(resp_paddr), .ptw_req(ptw_req), .ptw_addr(ptw_addr),
        .ptw_rvalid(ptw_rvalid), .ptw_rdata(ptw_rdata), .ptbase_we(ptbase_we),
        .ptbase_wdata(ptbase_wdata), .flush(flush), .pc_set(pc_set), .pc_wdata(pc_wdata),
        .rfe(rfe), .pc(pc), .epc(epc), .badva(badva), .cause(cause), .trap(trap));

    // Page-table memory model: frame = vpn ^ 8'hA5, 2-cycle latency
    logic        pt_valid [256];
    logic [15:0] cur_base = 0, last_ptw_addr = 0, addr_q = 0;
    logic [1:0]  lat = 0;
    int          walks = 0;
    logic [7:0]  idx;
    assign idx = 8'(addr_q - cur_base);

    always @(posedge clk) begin
        ptw_rvalid <= 1'b0;
        if (ptw_req) begin
            lat <= 2'd2; addr_q <= ptw_addr; last_ptw_addr <= ptw_addr; walks <= walks + 1;
        end else if (lat != 0) begin
            lat <= lat - 1'b1;
            if (lat == 2'd1) begin
                ptw_rvalid <= 1'b1;
                ptw_rdata  <= {pt_valid[idx], idx ^ 8'hA5};
            end
        end
    end

    int errors = 0, checks = 0;

    task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    logic        r_resp, r_trap, r_early, r_trap_after;
    logic [15:0] r_paddr;
    int          r_walks;

    task automatic access(input logic [1:0] kind, input logic [15:0] va);
        int w0;
        logic outst;
        @(negedge clk);
        req_valid = 1; req_kind = kind; req_vaddr = va;
        w0 = walks; outst = 0;
        r_resp = 0; r_trap = 0; r_early = 0; r_trap_after = 0; r_paddr = 0;
        @(negedge clk);
        req_valid = 0;
        for (int i = 0; i < 40; i++) begin
            if (ptw_req) outst = 1;
            if (ptw_rvalid) outst = 0;
            if (resp_valid) begin r_resp = 1; r_paddr = resp_paddr; r_early = outst; break; end
            if (trap) begin r_trap = 1; break; end
            @(negedge clk);
        end
        r_walks = walks - w0;
        if (r_trap) begin
            @(negedge clk);
            r_trap_after = trap;
        end
    endtask

    task automatic pulse_rfe();
        @(negedge clk); rfe = 1;
        @(negedge clk); rfe = 0;
    endtask

    // {exp_fault, exp_walk, kind[1:0], vaddr[15:0]}
    localparam logic [19:0] VEC [6] = '{
        {1'b0, 1'b1, 2'd0, 16'h1234},
        {1'b0, 1'b0, 2'd1, 16'h12F0},
        {1'b0, 1'b1, 2'd2, 16'h3410},
        {1'b1, 1'b1, 2'd1, 16'h3300},
        {1'b1, 1'b1, 2'd0, 16'h4400},
        {1'b0, 1'b0, 2'd2, 16'h34AA}
    };

    initial begin
        #(5.0 * 150000);
        errors++; checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        for (int i = 0; i < 256; i++) pt_valid[i] = 1'b1;
        pt_valid[8'h33] = 1'b0;
        pt_valid[8'h44] = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk(pc == 16'h0 && cause == 2'd0, "R1 pc/cause", {pc, 14'b0, cause}, 0);
        chk(!trap && !resp_valid && !ptw_req && req_ready, "R1 control",
            {trap, resp_valid, ptw_req, req_ready}, 32'h1);

        ptbase_we = 1; ptbase_wdata = 16'h0200; cur_base = 16'h0200;
        @(negedge clk); ptbase_we = 0;
        pc_set = 1; pc_wdata = 16'h0040;
        @(negedge clk); pc_set = 0;
        chk(pc == 16'h0040, "R7 pc_set", pc, 16'h0040);

        foreach (VEC[v]) begin
            logic        ef, ew;
            logic [1:0]  k;
            logic [15:0] va, pc_before;
            {ef, ew, k, va} = VEC[v];
            pc_before = pc;
            access(k, va);
            chk(r_walks == (ew ? 1 : 0), ew ? "R3 walk count" : "R2 hit no walk", r_walks, ew);
            if (ew) chk(last_ptw_addr == cur_base + {8'h0, va[15:8]}, "R3 walk address",
                        last_ptw_addr, cur_base + {8'h0, va[15:8]});
            if (!ef) begin
                chk(r_resp && !r_early, "R4 response after walk", {r_resp, r_early}, 2);
                chk(r_paddr == {va[15:8] ^ 8'hA5, va[7:0]}, "R2 paddr", r_paddr,
                    {va[15:8] ^ 8'hA5, va[7:0]});
            end else begin
                chk(r_trap && !r_resp && !r_trap_after, "R5 trap pulse",
                    {r_trap, r_resp, r_trap_after}, 3'b100);
                chk(cause == k + 2'd1, "R5 cause", cause, k + 2'd1);
                chk(epc == pc_before && badva == va && pc == HANDLER, "R5 saved state",
                    {epc, badva}, {pc_before, va});
                pulse_rfe();
                chk(pc == pc_before && cause == 2'd0, "R6 rfe restore", {pc, 14'b0, cause},
                    {pc_before, 16'h0});
            end
        end

        // R6 retry after repair, then R4 hit
        pt_valid[8'h33] = 1'b1;
        access(2'd1, 16'h3300);
        chk(r_resp && r_walks == 1 && r_paddr == 16'h9600, "R6 retry completes", r_paddr, 16'h9600);
        access(2'd1, 16'h3301);
        chk(r_resp && r_walks == 0, "R4 refilled entry hits", r_walks, 0);

        // R5 store fault cause 3 (kind 3 treated as store)
        access(2'd3, 16'h4410);
        chk(r_trap && cause == 2'd3, "R5 store cause", cause, 3);
        pulse_rfe();

        // R8 flush
        @(negedge clk); flush = 1;
        @(negedge clk); flush = 0;
        access(2'd0, 16'h1234);
        chk(r_walks == 1, "R8 flush forces walk", r_walks, 1);

        // R9 base write
        @(negedge clk); ptbase_we = 1; ptbase_wdata = 16'h0300; cur_base = 16'h0300;
        @(negedge clk); ptbase_we = 0;
        access(2'd1, 16'h1200);
        chk(r_walks == 1 && last_ptw_addr == 16'h0312, "R9 new base", last_ptw_addr, 16'h0312);

        // R10 round robin: 0x12 in entry 0, fill 1..3, then 0x23 evicts 0x12
        access(2'd1, 16'h2000); access(2'd1, 16'h2100); access(2'd1, 16'h2200);
        access(2'd1, 16'h1201);
        chk(r_walks == 0, "R10 full cache still hits", r_walks, 0);
        access(2'd1, 16'h2300);
        access(2'd1, 16'h2001);
        chk(r_walks == 0, "R10 newer entry kept", r_walks, 0);
        access(2'd1, 16'h1202);
        chk(r_walks == 1, "R10 oldest evicted", r_walks, 1);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule